// File: doc/BRIEF.md
# Synchronizable ramp oscillator sequencer

This block is a clocked model of the timing oscillator in a flyback power controller. A ramp count moves through three phases: it rises during charge, falls during discharge and waits at the valley level in a hold phase until a new charge is allowed. Analog slopes are replaced by fixed per-clock increments, `CHG_STEP` upward and `DIS_STEP` downward. The ratio of the two steps sets how much of a free-running period is spent falling. With the default 1:3 ratio, the discharge step is 75 % of the sum of the two steps.

There are two modes. In free-running mode, a charge starts whenever the converter reports dead time, and it ends at the peak level. In synchronized mode, a charge starts only while the sync level is high during dead time. It ends once the sync level has dropped and the ramp has passed an intermediate level, so any pulse width gives a proper cycle. Two outputs come from the ramp. The calibrated pulse `sf_o` marks the early part of each charge. The request `vs_o` asks the PWM stage for a new conduction and is withdrawn as soon as the PWM latch reports that it is set.

The state machine has three states: HOLD (code 0), CHARGE (code 1) and DISCH (code 2). It has four transitions:
- start: HOLD to CHARGE.
- peak stop: CHARGE to DISCH, in free-running mode.
- sync stop: CHARGE to DISCH, in synchronized mode.
- valley arrival: DISCH to HOLD.

Top module: `ramp_sync_osc`

## Requirements
- R1: `ramp_o` always lies between `VALLEY` and `PEAK`, inclusive.
- R2: While `rst` is high, and on the first cycle after it is released, `phase_o` is HOLD (0), `ramp_o` equals `VALLEY`, and `sf_o` and `vs_o` are low.
- R3: In HOLD the ramp sits at `VALLEY`. The start transition to CHARGE (1) happens on the next clock only if `dead_time_i` is high and either `free_mode_i` or `sync_i` is high. Otherwise the block stays in HOLD.
- R4: In CHARGE, unless a stop transition is taken, `ramp_o` rises by `CHG_STEP` per clock and saturates at `PEAK`.
- R5: With `free_mode_i` high, a CHARGE cycle that sees `ramp_o` at `PEAK` takes the peak stop to DISCH (2) on the next clock, with the ramp unchanged. With dead time always present, the free-running period is ceil((PEAK-VALLEY)/CHG_STEP)+1 clocks of CHARGE, plus ceil((PEAK-VALLEY)/DIS_STEP) clocks of DISCH, plus one clock of HOLD.
- R6: With `free_mode_i` low, CHARGE continues while `sync_i` is high. The sync stop to DISCH is taken on the clock after a cycle in which `sync_i` is low and `ramp_o` is above `MID`. A one-clock sync pulse therefore peaks at the first ramp value above `MID`.
- R7: In DISCH, `ramp_o` falls by `DIS_STEP` per clock. On the clock where that step would reach or pass `VALLEY`, the ramp loads `VALLEY` and the phase becomes HOLD in the same clock. DISCH never shows the valley value.
- R8: `sf_o` is high exactly when the phase is CHARGE and `ramp_o` is below `MID`.
- R9: `vs_o` goes high in the cycle `sf_o` rises, if `pwm_latch_i` is low. It is low in any cycle with `pwm_latch_i` high. After such a cycle it stays low until the next rising edge of `sf_o`.
- R10: With `free_mode_i` high, the level on `sync_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| free_mode_i | input | 1 | 1 = free-running, sync level ignored |
| sync_i | input | 1 | Sync level, high = sync condition met |
| dead_time_i | input | 1 | Converter is in dead time (core demagnetized) |
| pwm_latch_i | input | 1 | PWM latch output, high = conduction ended |
| ramp_o | output | RAMP_W | Ramp count |
| phase_o | output | 2 | Phase: 0 HOLD, 1 CHARGE, 2 DISCH |
| sf_o | output | 1 | Calibrated early-charge pulse |
| vs_o | output | 1 | Conduction request to the PWM stage |

## Verification
A wrong phase register shows up on `phase_o` in the same clock. Within a cycle it also shows up as a ramp that moves the wrong way or stalls. A ramp value that is off by a single step is visible on `ramp_o` at once. It also shifts the cycle at which `sf_o` falls and the free-running period by one or more clocks. A request flag left set or left clear shows on `vs_o` at the next rising edge of `sf_o`, or at the first PWM latch pulse. The bench therefore compares every output on every clock against a reference model, so a fault is caught in the cycle it first reaches a port.

// File: rtl/rso_pkg.sv
package rso_pkg;
    typedef enum logic [1:0] {
        PH_HOLD   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_DISCH  = 2'd2
    } ramp_phase_e;
endpackage

// File: rtl/rso_phase_fsm.sv
module rso_phase_fsm
    import rso_pkg::*;
#(
    parameter int RAMP_W   = 8,
    parameter int VALLEY   = 32,
    parameter int PEAK     = 160,
    parameter int MID      = 64,
    parameter int CHG_STEP = 1,
    parameter int DIS_STEP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_mode,
    input  logic              sync_lvl,
    input  logic              dead_time,
    output ramp_phase_e       phase,
    output logic [RAMP_W-1:0] ramp
);
    localparam logic [RAMP_W-1:0] VAL_L  = RAMP_W'(VALLEY);
    localparam logic [RAMP_W-1:0] PEAK_L = RAMP_W'(PEAK);
    localparam logic [RAMP_W-1:0] MID_L  = RAMP_W'(MID);
    localparam logic [RAMP_W:0]   CHG_X  = (RAMP_W+1)'(CHG_STEP);
    localparam logic [RAMP_W:0]   PEAK_X = (RAMP_W+1)'(PEAK);
    localparam logic [RAMP_W:0]   DN_LIM = (RAMP_W+1)'(VALLEY + DIS_STEP);
    localparam logic [RAMP_W-1:0] DIS_L  = RAMP_W'(DIS_STEP);

    ramp_phase_e       phase_q, phase_d;
    logic [RAMP_W-1:0] ramp_q, ramp_d;
    logic [RAMP_W:0]   up_sum;
    logic              start_ok, stop_chg;

    assign up_sum   = {1'b0, ramp_q} + CHG_X;
    assign start_ok = dead_time && (free_mode || sync_lvl);
    assign stop_chg = free_mode ? (ramp_q >= PEAK_L)
                                : (!sync_lvl && (ramp_q > MID_L));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            ramp_q  <= VAL_L;
        end else begin
            phase_q <= phase_d;
            ramp_q  <= ramp_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        ramp_d  = ramp_q;
        unique case (phase_q)
            PH_HOLD: begin
                ramp_d = VAL_L;
                if (start_ok) phase_d = PH_CHARGE;
            end
            PH_CHARGE: begin
                if (stop_chg) phase_d = PH_DISCH;
                else if (up_sum >= PEAK_X) ramp_d = PEAK_L;
                else ramp_d = up_sum[RAMP_W-1:0];
            end
            PH_DISCH: begin
                if ({1'b0, ramp_q} <= DN_LIM) begin
                    ramp_d  = VAL_L;
                    phase_d = PH_HOLD;
                end else begin
                    ramp_d = ramp_q - DIS_L;
                end
            end
            default: begin
                phase_d = PH_HOLD;
                ramp_d  = VAL_L;
            end
        endcase
    end

    assign phase = phase_q;
    assign ramp  = ramp_q;

    assert_ramp_range_R1: assert property (@(posedge clk) disable iff (rst)
        (ramp_q >= VAL_L) && (ramp_q <= PEAK_L));

    assert_hold_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && !(dead_time && (free_mode || sync_lvl)))
        |=> (phase_q == PH_HOLD && ramp_q == VAL_L));

    assert_charge_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CHARGE) |=> (ramp_q >= $past(ramp_q)));

    assert_peak_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CHARGE && free_mode && ramp_q == PEAK_L)
        |=> (phase_q == PH_DISCH && $stable(ramp_q)));

    assert_sync_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CHARGE && !free_mode && sync_lvl) |=> (phase_q == PH_CHARGE));

    assert_disch_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DISCH)
        |=> ((phase_q == PH_HOLD && ramp_q == VAL_L)
             || (phase_q == PH_DISCH && ramp_q < $past(ramp_q) && ramp_q > VAL_L)));
endmodule

// File: rtl/rso_pulse_gen.sv
module rso_pulse_gen
    import rso_pkg::*;
#(
    parameter int RAMP_W = 8,
    parameter int MID    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_phase_e       phase,
    input  logic [RAMP_W-1:0] ramp,
    input  logic              pwm_latch,
    output logic              sf,
    output logic              vs
);
    localparam logic [RAMP_W-1:0] MID_L = RAMP_W'(MID);

    logic sf_c, sf_q, arm_q, sf_rise, vs_c;

    assign sf_c    = (phase == PH_CHARGE) && (ramp < MID_L);
    assign sf_rise = sf_c && !sf_q;
    assign vs_c    = !pwm_latch && (sf_rise || arm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sf_q  <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            sf_q  <= sf_c;
            arm_q <= vs_c;
        end
    end

    assign sf = sf_c;
    assign vs = vs_c;

    assert_sf_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sf_c) |-> ($past(phase) == PH_HOLD));

    assert_vs_block_R9: assert property (@(posedge clk) disable iff (rst)
        pwm_latch |-> !vs_c);

    assert_vs_origin_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(vs_c) |-> sf_c);

    assert_vs_stay_low_R9: assert property (@(posedge clk) disable iff (rst)
        (pwm_latch && !sf_rise) |=> (!vs_c || sf_rise));
endmodule

// File: rtl/ramp_sync_osc.sv
module ramp_sync_osc
    import rso_pkg::*;
#(
    parameter int RAMP_W   = 8,
    parameter int VALLEY   = 32,
    parameter int PEAK     = 160,
    parameter int MID      = 64,
    parameter int CHG_STEP = 1,
    parameter int DIS_STEP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_mode_i,
    input  logic              sync_i,
    input  logic              dead_time_i,
    input  logic              pwm_latch_i,
    output logic [RAMP_W-1:0] ramp_o,
    output logic [1:0]        phase_o,
    output logic              sf_o,
    output logic              vs_o
);
    ramp_phase_e       phase_w;
    logic [RAMP_W-1:0] ramp_w;

    rso_phase_fsm #(
        .RAMP_W(RAMP_W), .VALLEY(VALLEY), .PEAK(PEAK), .MID(MID),
        .CHG_STEP(CHG_STEP), .DIS_STEP(DIS_STEP)
    ) u_fsm (
        .clk(clk), .rst(rst), .free_mode(free_mode_i), .sync_lvl(sync_i),
        .dead_time(dead_time_i), .phase(phase_w), .ramp(ramp_w)
    );

    rso_pulse_gen #(.RAMP_W(RAMP_W), .MID(MID)) u_pulse (
        .clk(clk), .rst(rst), .phase(phase_w), .ramp(ramp_w),
        .pwm_latch(pwm_latch_i), .sf(sf_o), .vs(vs_o)
    );

    assign ramp_o  = ramp_w;
    assign phase_o = phase_w;
endmodule

// File: tb/sim_ramp_sync_osc.sv
`timescale 1ns/1ps
module sim_ramp_sync_osc;
    localparam int RAMP_W = 8, VALLEY = 32, PEAK = 160, MID = 64;
    localparam int CHG_STEP = 1, DIS_STEP = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic free_mode_i = 1'b1, sync_i = 1'b0, dead_time_i = 1'b0, pwm_latch_i = 1'b0;
    logic [RAMP_W-1:0] ramp_o;
    logic [1:0] phase_o;
    logic sf_o, vs_o;

    always #4 clk = ~clk;

    ramp_sync_osc #(.RAMP_W(RAMP_W), .VALLEY(VALLEY), .PEAK(PEAK), .MID(MID),
                    .CHG_STEP(CHG_STEP), .DIS_STEP(DIS_STEP)) u0 (
        .clk(clk), .rst(rst), .free_mode_i(free_mode_i), .sync_i(sync_i),
        .dead_time_i(dead_time_i), .pwm_latch_i(pwm_latch_i),
        .ramp_o(ramp_o), .phase_o(phase_o), .sf_o(sf_o), .vs_o(vs_o));

    int checks = 0, failures = 0;
    bit done = 0;
    int mph, mram, msfq, marm;
    int cyc = 0, last_rise = 0, rise_cnt = 0, last_period = 0, ramp_max = 0, vs_hi = 0;
    bit prev_sf = 0;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int free_period();
        return cdiv(PEAK - VALLEY, CHG_STEP) + 1 + cdiv(PEAK - VALLEY, DIS_STEP) + 1;
    endfunction

    function automatic int narrow_peak();
        return VALLEY + CHG_STEP * ((MID - VALLEY) / CHG_STEP + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        mph = 0; mram = VALLEY; msfq = 0; marm = 0;
    endtask

    task automatic step(input logic fm, input logic sy, input logic dt, input logic pw);
        int e_sf, rise, e_vs, nph, nram, stop;
        free_mode_i = fm; sync_i = sy; dead_time_i = dt; pwm_latch_i = pw;
        #1;
        e_sf = (mph == 1 && mram < MID) ? 1 : 0;
        rise = (e_sf == 1 && msfq == 0) ? 1 : 0;
        e_vs = (!pw && (rise == 1 || marm == 1)) ? 1 : 0;
        chk(int'(phase_o) == mph, "R3 R5 R6 R10 phase", int'(phase_o), mph);
        chk(int'(ramp_o) == mram, "R4 R7 ramp", int'(ramp_o), mram);
        chk(int'(sf_o) == e_sf, "R8 sf", int'(sf_o), e_sf);
        chk(int'(vs_o) == e_vs, "R9 vs", int'(vs_o), e_vs);
        chk(int'(ramp_o) >= VALLEY && int'(ramp_o) <= PEAK, "R1 range", int'(ramp_o), VALLEY);
        if (sf_o && !prev_sf) begin
            if (rise_cnt > 0) last_period = cyc - last_rise;
            last_rise = cyc;
            rise_cnt++;
        end
        prev_sf = sf_o;
        if (int'(ramp_o) > ramp_max) ramp_max = int'(ramp_o);
        if (vs_o) vs_hi++;
        nph = mph; nram = mram;
        if (mph == 0) begin
            nram = VALLEY;
            if (dt && (fm || sy)) nph = 1;
        end else if (mph == 1) begin
            stop = fm ? (mram >= PEAK) : (!sy && mram > MID);
            if (stop) nph = 2;
            else nram = (mram + CHG_STEP > PEAK) ? PEAK : mram + CHG_STEP;
        end else begin
            if (mram - DIS_STEP <= VALLEY) begin nph = 0; nram = VALLEY; end
            else nram = mram - DIS_STEP;
        end
        marm = e_vs; msfq = e_sf;
        @(negedge clk);
        cyc++;
        mph = nph; mram = nram;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(phase_o == 2'd0, "R2 reset phase", int'(phase_o), 0);
        chk(int'(ramp_o) == VALLEY, "R2 reset ramp", int'(ramp_o), VALLEY);
        chk(sf_o == 1'b0, "R2 reset sf", int'(sf_o), 0);
        chk(vs_o == 1'b0, "R2 reset vs", int'(vs_o), 0);
        rst = 1'b0;
        model_reset();
        prev_sf = 0; rise_cnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed, burst, len;
        logic fm, sy, dt, pw;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        // R3: free mode without dead time never leaves HOLD
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0);
        chk(phase_o == 2'd0, "R3 no dead time stays HOLD", int'(phase_o), 0);

        // R5 R10: free-run period with sync toggling every clock
        for (int i = 0; i < 4 * free_period(); i++) step(1, i[0], 1, 0);
        chk(rise_cnt >= 3, "R5 free run cycles", rise_cnt, 3);
        chk(last_period == free_period(), "R5 R10 free-run period", last_period, free_period());

        // R6: sync mode, one-clock pulse
        do_reset();
        for (int i = 0; i < 20; i++) step(0, 0, 1, 0);
        chk(phase_o == 2'd0, "R3 sync low stays HOLD", int'(phase_o), 0);
        ramp_max = 0;
        step(0, 1, 1, 0);
        for (int i = 0; i < 200; i++) step(0, 0, 1, 0);
        chk(ramp_max == narrow_peak(), "R6 narrow pulse peak", ramp_max, narrow_peak());
        chk(phase_o == 2'd0, "R6 waits for next pulse", int'(phase_o), 0);

        // R4 R7: wide pulse saturates at PEAK, then falls back to HOLD
        for (int i = 0; i < 250; i++) step(0, 1, 1, 0);
        chk(int'(ramp_o) == PEAK, "R4 saturates at PEAK", int'(ramp_o), PEAK);
        chk(phase_o == 2'd1, "R6 charge held by sync", int'(phase_o), 1);
        for (int i = 0; i < 80; i++) step(0, 0, 1, 0);
        chk(phase_o == 2'd0, "R7 discharge reaches HOLD", int'(phase_o), 0);

        // R9: PWM latch high across the Sf edge suppresses VS
        do_reset();
        vs_hi = 0;
        for (int i = 0; i < 60; i++) step(1, 0, 1, 1);
        for (int i = 0; i < 40; i++) step(1, 0, 1, 0);
        chk(vs_hi == 0, "R9 vs blocked until next Sf rise", vs_hi, 0);

        // Random mix
        burst = 0;
        for (int seg = 0; seg < 40; seg++) begin
            fm = 1'($urandom % 2);
            dt = 1'b1; pw = 1'b0; sy = 1'b0;
            len = 100 + int'($urandom % 300);
            for (int i = 0; i < len; i++) begin
                if ($urandom % 20 == 0) dt = ~dt;
                if ($urandom % 15 == 0) pw = ~pw;
                if (burst > 0) burst--;
                else if ($urandom % 40 == 0) burst = 1 + int'($urandom % 120);
                sy = (burst > 0);
                step(fm, sy, dt, pw);
            end
            if (seg % 10 == 9) do_reset();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule